// File: doc/BRIEF.md
# Flash Program/Erase Protection Checker

This block sits between the command decoder of a serial flash controller and its array sequencer. It decides whether a program, sector erase, block erase or chip erase request may start. The inputs are the request type and target address, plus the device status the decoder already holds:

- the write-enable latch and the busy flag;
- a 4-bit protection level;
- a select bit that puts the protected region at the high or low end of the array.

Each request gets exactly one answer, either a grant or a reject. With that answer comes a strobe telling the status logic to clear its write-enable latch.

The protected region is a power-of-two number of the smallest erase units. The protection level sets that number, and the region is anchored at one end of the array. Each request is first widened to the byte span it would touch: one byte for a program, an aligned sector or block for the erase types, and the whole array for chip erase. The request is rejected if that span meets the protected region at all. Running the array operation and timing it is left to the sequencer that consumes the grant.

Top module: `flash_prot_checker`

## Requirements
- R1: A request presented while the write-enable input is 0 is answered with a reject.
- R2: A request presented while the busy input is 1 is answered with a reject.
- R3: With protection level 0 nothing is protected, so an enabled, idle program, sector-erase, block-erase or chip-erase request to any address is granted.
- R4: For a protection level n from 1 to 15, the protected size is 2^(n-1) sectors of 2^SEC_W bytes, limited to the whole array. With the defaults (22-bit address, 4 KiB sectors), level 11 and above cover all of it.
- R5: With the anchor select at 0, the protected region is the top `size` bytes of the array, from 2^ADDR_W-size to 2^ADDR_W-1.
- R6: With the anchor select at 1, the protected region is the bottom `size` bytes, from 0 to size-1.
- R7: Request codes are 2'b00 program (one byte), 2'b01 sector erase (2^SEC_W bytes), 2'b10 block erase (2^BLK_W bytes) and 2'b11 chip erase. For the erase types, the span is the address aligned down to the erase size. A request whose span overlaps the protected region in any byte is rejected.
- R8: A chip erase (code 2'b11) is granted only when the protection level is 0.
- R9: A request sampled at a clock edge is answered at that edge by exactly one of grant or reject, each a single-cycle pulse. Without a request, both stay low.
- R10: The write-enable clear strobe pulses in the same cycle as every grant and every reject, and at no other time.
- R11: During and immediately after reset, grant, reject and the clear strobe are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Request code (see R7) |
| req_addr | input | ADDR_W | Target byte address |
| wel | input | 1 | Write-enable latch state |
| wip | input | 1 | Device busy flag |
| prot_lvl | input | LVL_W | Protection level |
| prot_bottom | input | 1 | 0 anchors the region at the top, 1 at the bottom |
| grant | output | 1 | Request may start (one-cycle pulse) |
| reject | output | 1 | Request refused (one-cycle pulse) |
| wel_clr | output | 1 | Clear the write-enable latch (one-cycle pulse) |

## Verification
The bench probes the addresses on either side of every region boundary, at both anchors. A design that is off by one in the region limits grants the first protected byte or refuses the last free one. Erase requests that start in free space but whose aligned block reaches into the region catch a design that compares only the raw address. Levels at and above the cap catch a size computation that wraps to zero or overflows, and such a design would unprotect the whole array. Chip erase under a nonzero level, and requests made while busy or without write enable, catch gates applied in the wrong order or not at all.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;

   typedef enum logic [1:0] {
      OP_PROG  = 2'b00,
      OP_SECT  = 2'b01,
      OP_BLOCK = 2'b10,
      OP_CHIP  = 2'b11
   } fp_op_e;

   typedef struct packed {
      logic grant;
      logic reject;
      logic wel_clr;
   } fp_resp_t;

endpackage

// File: rtl/fp_prot_window.sv
module fp_prot_window #(
   parameter int ADDR_W = 22,
   parameter int SEC_W  = 12,
   parameter int LVL_W  = 4
) (
   input  logic [LVL_W-1:0] lvl,
   input  logic             bottom,
   output logic [ADDR_W:0]  win_lo,
   output logic [ADDR_W:0]  win_hi,
   output logic             win_none
);
   localparam int NLVL = 1 << LVL_W;
   localparam logic [ADDR_W:0] ONE = {{ADDR_W{1'b0}}, 1'b1};
   localparam logic [ADDR_W:0] ARR = ONE << ADDR_W;

   logic [ADDR_W:0] size_tab [NLVL];
   logic [ADDR_W:0] size;

   for (genvar i = 0; i < NLVL; i++) begin : g_lvl
      localparam int EXP = (i == 0) ? 0 :
                           ((i - 1 + SEC_W > ADDR_W) ? ADDR_W : (i - 1 + SEC_W));
      if (i == 0) begin : g_open
         assign size_tab[i] = '0;
      end else begin : g_sized
         assign size_tab[i] = ONE << EXP;
      end
   end

   assign size     = size_tab[lvl];
   assign win_none = (size == '0);

   always_comb begin
      if (bottom) begin
         win_lo = '0;
         win_hi = size - ONE;
      end else begin
         win_lo = ARR - size;
         win_hi = ARR - ONE;
      end
   end

endmodule

// File: rtl/fp_op_span.sv
module fp_op_span
   import flash_prot_pkg::*;
#(
   parameter int ADDR_W = 22,
   parameter int SEC_W  = 12,
   parameter int BLK_W  = 16
) (
   input  fp_op_e          op,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W:0] span_lo,
   output logic [ADDR_W:0] span_hi
);
   localparam logic [ADDR_W:0] ONE      = {{ADDR_W{1'b0}}, 1'b1};
   localparam logic [ADDR_W:0] SEC_LOW  = (ONE << SEC_W) - ONE;
   localparam logic [ADDR_W:0] BLK_LOW  = (ONE << BLK_W) - ONE;
   localparam logic [ADDR_W:0] ARR_LAST = (ONE << ADDR_W) - ONE;

   logic [ADDR_W:0] a_ext;
   assign a_ext = {1'b0, addr};

   always_comb begin
      unique case (op)
         OP_PROG: begin
            span_lo = a_ext;
            span_hi = a_ext;
         end
         OP_SECT: begin
            span_lo = a_ext & ~SEC_LOW;
            span_hi = (a_ext & ~SEC_LOW) | SEC_LOW;
         end
         OP_BLOCK: begin
            span_lo = a_ext & ~BLK_LOW;
            span_hi = (a_ext & ~BLK_LOW) | BLK_LOW;
         end
         default: begin
            span_lo = '0;
            span_hi = ARR_LAST;
         end
      endcase
   end

endmodule

// File: rtl/fp_overlap.sv
module fp_overlap #(
   parameter int W = 23
) (
   input  logic [W-1:0] a_lo,
   input  logic [W-1:0] a_hi,
   input  logic [W-1:0] b_lo,
   input  logic [W-1:0] b_hi,
   input  logic         b_empty,
   output logic         hit
);
   assign hit = !b_empty && (a_lo <= b_hi) && (a_hi >= b_lo);
endmodule

// File: rtl/flash_prot_checker.sv
module flash_prot_checker
   import flash_prot_pkg::*;
#(
   parameter int ADDR_W = 22,
   parameter int SEC_W  = 12,
   parameter int BLK_W  = 16,
   parameter int LVL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              wel,
   input  logic              wip,
   input  logic [LVL_W-1:0]  prot_lvl,
   input  logic              prot_bottom,
   output logic              grant,
   output logic              reject,
   output logic              wel_clr
);
   localparam int SPAN_W = ADDR_W + 1;

   if (SEC_W < 1 || SEC_W >= BLK_W || BLK_W > ADDR_W) begin : g_bad_sizes
      $error("flash_prot_checker: need 1 <= SEC_W < BLK_W <= ADDR_W");
   end
   if (LVL_W < 1 || LVL_W > 5) begin : g_bad_lvl
      $error("flash_prot_checker: LVL_W must be 1..5");
   end

   fp_op_e            op;
   logic [SPAN_W-1:0] win_lo, win_hi, span_lo, span_hi;
   logic              win_none, hit, chip_blocked, allow;
   fp_resp_t          resp_d, resp_q;

   assign op = fp_op_e'(req_op);

   fp_prot_window #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .LVL_W(LVL_W)) u_window (
      .lvl      (prot_lvl),
      .bottom   (prot_bottom),
      .win_lo   (win_lo),
      .win_hi   (win_hi),
      .win_none (win_none)
   );

   fp_op_span #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .BLK_W(BLK_W)) u_span (
      .op      (op),
      .addr    (req_addr),
      .span_lo (span_lo),
      .span_hi (span_hi)
   );

   fp_overlap #(.W(SPAN_W)) u_overlap (
      .a_lo    (span_lo),
      .a_hi    (span_hi),
      .b_lo    (win_lo),
      .b_hi    (win_hi),
      .b_empty (win_none),
      .hit     (hit)
   );

   assign chip_blocked = (op == OP_CHIP) && (prot_lvl != '0);
   assign allow        = wel && !wip && !hit && !chip_blocked;

   always_comb begin
      resp_d.grant   = req_valid && allow;
      resp_d.reject  = req_valid && !allow;
      resp_d.wel_clr = req_valid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) resp_q <= '0;
      else        resp_q <= resp_d;
   end

   assign grant   = resp_q.grant;
   assign reject  = resp_q.reject;
   assign wel_clr = resp_q.wel_clr;

endmodule

// File: rtl/fp_checker.sv
module fp_checker #(
   parameter int ADDR_W = 22,
   parameter int SEC_W  = 12,
   parameter int LVL_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_op,
   input logic [ADDR_W-1:0] req_addr,
   input logic              wel,
   input logic              wip,
   input logic [LVL_W-1:0]  prot_lvl,
   input logic              prot_bottom,
   input logic              grant,
   input logic              reject,
   input logic              wel_clr
);
   localparam logic [ADDR_W:0] ARR = {1'b1, {ADDR_W{1'b0}}};

   logic [ADDR_W:0] c_size;
   logic            prog_hit;

   always_comb begin
      c_size = '0;
      if (prot_lvl != '0) begin
         if (int'(prot_lvl) + SEC_W - 1 >= ADDR_W) c_size = ARR;
         else c_size = ARR >> (ADDR_W - (int'(prot_lvl) + SEC_W - 1));
      end
      if (prot_bottom) prog_hit = ({1'b0, req_addr} < c_size);
      else             prog_hit = (c_size != '0) && ({1'b0, req_addr} >= ARR - c_size);
   end

   AST_RESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant && reject));                                              // R9
   AST_RESP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (grant ^ reject));                                  // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!grant && !reject && !wel_clr));                  // R9
   AST_WELCLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> wel_clr);                                           // R10
   AST_WEL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !wel) |=> reject);                                  // R1
   AST_WIP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && wip) |=> reject);                                   // R2
   AST_CHIP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'b11 && prot_lvl != '0) |=> reject);     // R8
   AST_LVL0_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && wel && !wip && prot_lvl == '0) |=> grant);          // R3
   AST_PROG_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 2'b00 && prog_hit) |=> reject);           // R5 R6

endmodule

bind flash_prot_checker fp_checker #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .LVL_W(LVL_W)) u_fp_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
   .req_addr(req_addr), .wel(wel), .wip(wip), .prot_lvl(prot_lvl),
   .prot_bottom(prot_bottom), .grant(grant), .reject(reject), .wel_clr(wel_clr)
);

// File: tb/flash_prot_checker_bench.sv
module flash_prot_checker_bench;
   localparam int AW = 22;
   localparam int SW = 12;
   localparam int BW = 16;
   localparam int LW = 4;
   localparam longint ARR = longint'(1) << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'b00;
   logic [AW-1:0] req_addr = '0;
   logic          wel = 1'b0;
   logic          wip = 1'b0;
   logic [LW-1:0] prot_lvl = '0;
   logic          prot_bottom = 1'b0;
   logic          grant, reject, wel_clr;

   int n_checks = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   flash_prot_checker #(.ADDR_W(AW), .SEC_W(SW), .BLK_W(BW), .LVL_W(LW)) u_flash_prot_checker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .wel(wel), .wip(wip), .prot_lvl(prot_lvl),
      .prot_bottom(prot_bottom), .grant(grant), .reject(reject), .wel_clr(wel_clr)
   );

   function automatic longint prot_size(int lvl);
      int e;
      if (lvl == 0) return 0;
      e = lvl - 1 + SW;
      if (e > AW) e = AW;
      return longint'(1) << e;
   endfunction

   function automatic bit model_ok(int op, longint a, bit we, bit busy, int lvl, bit bot);
      longint sz, plo, phi, olo, ohi;
      if (!we || busy) return 1'b0;
      if (op == 3 && lvl != 0) return 1'b0;
      if (lvl == 0) return 1'b1;
      sz = prot_size(lvl);
      if (bot) begin plo = 0; phi = sz - 1; end
      else     begin plo = ARR - sz; phi = ARR - 1; end
      case (op)
         0: begin olo = a; ohi = a; end
         1: begin olo = (a >> SW) << SW; ohi = olo + (longint'(1) << SW) - 1; end
         2: begin olo = (a >> BW) << BW; ohi = olo + (longint'(1) << BW) - 1; end
         default: begin olo = 0; ohi = ARR - 1; end
      endcase
      return !(olo <= phi && ohi >= plo);
   endfunction

   function automatic string reason_tag(int op, bit we, bit busy, int lvl, bit bot);
      if (!we) return "R1";
      if (busy) return "R2";
      if (op == 3) return "R8";
      if (lvl == 0) return "R3";
      if (op != 0) return "R7";
      return bot ? "R6" : "R5";
   endfunction

   task automatic check(string tag, logic [2:0] got, logic [2:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: {grant,reject,wel_clr} got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic do_req(int op, longint a, bit we, bit busy, int lvl, bit bot, string tag);
      bit ok;
      ok = model_ok(op, a, we, busy, lvl, bot);
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'(op); req_addr = AW'(a);
      wel = we; wip = busy; prot_lvl = LW'(lvl); prot_bottom = bot;
      @(negedge clk);
      req_valid = 1'b0;
      check(tag, {grant, reject, 1'b0}, {ok, !ok, 1'b0});
      check("R10", {2'b00, wel_clr}, 3'b001);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h5EED_0F1A;
      void'($urandom(seed));

      repeat (3) @(negedge clk);
      check("R11", {grant, reject, wel_clr}, 3'b000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R11", {grant, reject, wel_clr}, 3'b000);

      // R1, R2 gates
      do_req(0, 100, 0, 0, 0, 0, "R1");
      do_req(1, 100, 1, 1, 0, 0, "R2");
      // R3 level 0 open everywhere
      do_req(0, ARR - 1, 1, 0, 0, 0, "R3");
      do_req(2, 0, 1, 0, 0, 1, "R3");
      do_req(3, 0, 1, 0, 0, 0, "R8");
      // R5 top anchor, level 1
      do_req(0, ARR - 4096, 1, 0, 1, 0, "R5");
      do_req(0, ARR - 4097, 1, 0, 1, 0, "R5");
      // R6 bottom anchor, level 1
      do_req(0, 4095, 1, 0, 1, 1, "R6");
      do_req(0, 4096, 1, 0, 1, 1, "R6");
      // R4 size steps and cap
      do_req(0, 32'h1F_FFFF, 1, 0, 10, 0, "R4");
      do_req(0, 32'h20_0000, 1, 0, 10, 0, "R4");
      do_req(0, 0, 1, 0, 11, 0, "R4");
      do_req(0, ARR - 1, 1, 0, 15, 1, "R4");
      // R7 aligned erase spans
      do_req(2, ARR - 65536 + 5, 1, 0, 1, 0, "R7");
      do_req(2, ARR - 131072 + 9, 1, 0, 1, 0, "R7");
      do_req(1, ARR - 8192 + 7, 1, 0, 1, 0, "R7");
      do_req(1, 4096 + 3, 1, 0, 2, 1, "R7");
      do_req(2, 65535, 1, 0, 5, 1, "R7");
      // R8 chip erase blocked by any level
      do_req(3, 0, 1, 0, 1, 1, "R8");
      // R9 idle: no response without a request
      @(negedge clk);
      check("R9", {grant, reject, wel_clr}, 3'b000);

      for (int k = 0; k < 4000; k++) begin
         int op, lvl;
         bit we, busy, bot;
         longint a, sz, edge_a;
         op   = $urandom_range(3, 0);
         lvl  = $urandom_range(15, 0);
         bot  = $urandom_range(1, 0);
         we   = ($urandom_range(7, 0) != 0);
         busy = ($urandom_range(7, 0) == 0);
         sz   = prot_size(lvl);
         if ($urandom_range(1, 0) == 1 && sz != 0 && sz < ARR) begin
            edge_a = bot ? sz : ARR - sz;
            a = edge_a + longint'($urandom_range(4, 0)) - 2;
            if ($urandom_range(1, 0) == 1)
               a = edge_a + longint'($urandom_range(131072, 0)) - 65536;
            if (a < 0) a = 0;
            if (a >= ARR) a = ARR - 1;
         end else begin
            a = longint'($urandom_range(AW'('1), 0));
         end
         do_req(op, a, we, busy, lvl, bot, reason_tag(op, we, busy, lvl, bot));
      end

      @(negedge clk);
      check("R9", {grant, reject, wel_clr}, 3'b000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule